// File: doc/BRIEF.md
# Reset Vector Boot Sequencer

This block performs the start-up fetch of a small processor core once reset is released. It issues two single-word reads on a simple read port with a valid/ready handshake. The word at address 0x00000000 becomes the main stack pointer, with its low two bits forced to zero. The word at 0x00000004 becomes the program counter, which is the entry point of the reset handler. Once both words are loaded, the block raises a start signal. At the same time it reports thread mode and privileged access.

After start-up, the same read port serves a second job: exception entry lookups. A requester presents an exception number and holds a valid flag. The block reads the table word at `TABLE_BASE + 4*number`, which places NMI (2) at 0x08, HardFault (3) at 0x0C and external interrupt n (number 16+n) at 0x40+4n. It returns that word with bit 0 cleared, together with a flag that shows whether bit 0 was clear. In a valid handler address bit 0 must be 1, because that bit marks the compact instruction state.

The controller is a single state machine with these states:
- `BS_IDLE`: held during reset; no request is issued.
- `BS_LOAD_SP`: reads slot 0.
- `BS_LOAD_PC`: reads slot 1.
- `BS_RUN`: the core is started and the block waits for a lookup request.
- `BS_VEC_READ`: reads the requested slot.
- `BS_VEC_DONE`: a one-cycle completion.

The transitions are:
- `BS_IDLE`→`BS_LOAD_SP` on the first clock after reset.
- `BS_LOAD_SP`→`BS_LOAD_PC` on a handshake.
- `BS_LOAD_PC`→`BS_RUN` on a handshake.
- `BS_RUN`→`BS_VEC_READ` when `exc_valid` is high.
- `BS_VEC_READ`→`BS_VEC_DONE` on a handshake.
- `BS_VEC_DONE`→`BS_RUN` unconditionally.

Top module: `boot_vector_seq`

## Requirements
- R1: While `rst_n` is low, `mem_valid`, `core_start`, `thread_mode`, `privileged`, `exc_done` and `boot_fault` are all 0.
- R2: The first read after reset release targets address 0x00000000. The word it returns appears on `stack_ptr` with bits [1:0] forced to 0.
- R3: The second read targets address 0x00000004. The word it returns appears on `prog_ctr` with bit 0 forced to 0.
- R4: `boot_fault` becomes 1 when the second word has bit 0 equal to 0. It stays set until reset, and it is 0 otherwise.
- R5: `core_start`, `thread_mode` and `privileged` rise together in the cycle after the second handshake. They then stay high until reset.
- R6: While `mem_valid` is high and `mem_ready` is low, the request and its address hold unchanged in the next cycle. Any number of wait cycles is accepted.
- R7: A lookup for exception number k reads address `TABLE_BASE + 4*k`. With the default base this gives NMI (2) → 0x08, HardFault (3) → 0x0C, and IRQ n (16+n) → 0x40+4n.
- R8: `exc_done` is a one-cycle pulse in the cycle after the lookup handshake. While it is high, `exc_handler` equals the fetched word with bit 0 cleared, and `exc_fault` equals the inverse of the fetched bit 0.
- R9: An `exc_valid` raised before start-up is complete is not served until both start-up reads are done. It is then served, and the start-up reads keep addresses 0 and 4 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Read address |
| mem_valid | output | 1 | Read request valid |
| mem_ready | input | 1 | Read accepted; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | DATA_W | Read data |
| stack_ptr | output | DATA_W | Loaded main stack pointer (word aligned) |
| prog_ctr | output | DATA_W | Loaded reset entry address (bit 0 cleared) |
| core_start | output | 1 | Core may begin execution |
| thread_mode | output | 1 | Core starts in thread mode |
| privileged | output | 1 | Core starts with privileged access |
| boot_fault | output | 1 | Reset entry word had bit 0 clear |
| exc_valid | input | 1 | Lookup request; held until `exc_done` |
| exc_num | input | EXC_W | Exception number to look up |
| exc_done | output | 1 | Lookup complete (one-cycle pulse) |
| exc_handler | output | DATA_W | Handler address, bit 0 cleared |
| exc_fault | output | 1 | Fetched handler word had bit 0 clear |

## Verification
The two functions that can collide are the start-up fetch and an exception lookup. Both compete for the one read port. To provoke the collision, the bench raises a lookup request in the same cycle that reset is released, while the ready line inserts pseudo-random wait states. The reference model in the bench decides, cycle by cycle, which address must appear on the port. The collision is judged correct only if addresses 0 and 4 come first and stay held through every wait cycle. The lookup address may appear only after `core_start` has risen, and the result must then match the table word.

// File: rtl/bvs_pkg.sv
package bvs_pkg;
    typedef enum logic [2:0] {
        BS_IDLE,
        BS_LOAD_SP,
        BS_LOAD_PC,
        BS_RUN,
        BS_VEC_READ,
        BS_VEC_DONE
    } bvs_state_e;

    localparam int unsigned SLOT_SP = 0;
    localparam int unsigned SLOT_PC = 1;
endpackage

// File: rtl/bvs_slot_addr.sv
// Turns a table slot number into a byte address (word stride).
module bvs_slot_addr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SLOT_W = 6,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic [SLOT_W-1:0] slot,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned PAD_W = ADDR_W - SLOT_W - 2;

    always_comb begin
        addr = BASE + {{PAD_W{1'b0}}, slot, 2'b00};
    end
endmodule

// File: rtl/bvs_code_ptr.sv
// Splits a fetched code pointer into an even address and a state-bit check.
module bvs_code_ptr #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] target,
    output logic              state_bad
);
    always_comb begin
        target    = {word_in[DATA_W-1:1], 1'b0};
        state_bad = ~word_in[0];
    end
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
    import bvs_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned EXC_W  = 6,
    parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_valid,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] stack_ptr,
    output logic [DATA_W-1:0] prog_ctr,
    output logic              core_start,
    output logic              thread_mode,
    output logic              privileged,
    output logic              boot_fault,
    input  logic              exc_valid,
    input  logic [EXC_W-1:0]  exc_num,
    output logic              exc_done,
    output logic [DATA_W-1:0] exc_handler,
    output logic              exc_fault
);
    bvs_state_e state_q, state_d;
    logic [EXC_W-1:0]  num_q;
    logic [EXC_W-1:0]  slot;
    logic              xfer;
    logic [DATA_W-1:0] ptr_even;
    logic              ptr_bad;

    assign xfer = mem_valid & mem_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE:     state_d = BS_LOAD_SP;
            BS_LOAD_SP:  if (mem_ready) state_d = BS_LOAD_PC;
            BS_LOAD_PC:  if (mem_ready) state_d = BS_RUN;
            BS_RUN:      if (exc_valid) state_d = BS_VEC_READ;
            BS_VEC_READ: if (mem_ready) state_d = BS_VEC_DONE;
            BS_VEC_DONE: state_d = BS_RUN;
            default:     state_d = BS_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        mem_valid  = 1'b0;
        core_start = 1'b0;
        exc_done   = 1'b0;
        slot       = EXC_W'(SLOT_SP);
        unique case (state_q)
            BS_IDLE:     ;
            BS_LOAD_SP:  mem_valid = 1'b1;
            BS_LOAD_PC:  begin mem_valid = 1'b1; slot = EXC_W'(SLOT_PC); end
            BS_RUN:      core_start = 1'b1;
            BS_VEC_READ: begin mem_valid = 1'b1; slot = num_q; core_start = 1'b1; end
            BS_VEC_DONE: begin exc_done = 1'b1; core_start = 1'b1; end
            default:     ;
        endcase
        thread_mode = core_start;
        privileged  = core_start;
    end

    bvs_slot_addr #(.ADDR_W(ADDR_W), .SLOT_W(EXC_W), .BASE(TABLE_BASE)) u_addr (
        .slot (slot),
        .addr (mem_addr)
    );

    bvs_code_ptr #(.DATA_W(DATA_W)) u_ptr (
        .word_in   (mem_rdata),
        .target    (ptr_even),
        .state_bad (ptr_bad)
    );

    // Captured values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stack_ptr   <= '0;
            prog_ctr    <= '0;
            boot_fault  <= 1'b0;
            num_q       <= '0;
            exc_handler <= '0;
            exc_fault   <= 1'b0;
        end else begin
            if (state_q == BS_LOAD_SP && xfer)
                stack_ptr <= {mem_rdata[DATA_W-1:2], 2'b00};
            if (state_q == BS_LOAD_PC && xfer) begin
                prog_ctr   <= ptr_even;
                boot_fault <= ptr_bad;
            end
            if (state_q == BS_RUN && exc_valid)
                num_q <= exc_num;
            if (state_q == BS_VEC_READ && xfer) begin
                exc_handler <= ptr_even;
                exc_fault   <= ptr_bad;
            end
        end
    end

    // Assertions
    always @(posedge clk) begin
        if (!rst_n) begin
            p_quiet_in_reset_r1: assert (!mem_valid && !core_start && !exc_done && !boot_fault);
        end
    end

    p_hold_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    p_stack_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (stack_ptr[1:0] == 2'b00));

    p_entry_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (prog_ctr[0] == 1'b0));

    p_start_after_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_start) |-> $past(mem_valid && mem_ready && mem_addr == TABLE_BASE + ADDR_W'(4)));

    p_start_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> core_start);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_done |=> !exc_done);

    p_done_after_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_done) |-> $past(mem_valid && mem_ready && core_start));

    p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && boot_fault) |=> boot_fault);
endmodule

// File: tb/tb_boot_vector_seq.sv
module tb_boot_vector_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata;
    logic [31:0] stack_ptr, prog_ctr, exc_handler;
    logic        core_start, thread_mode, privileged, boot_fault;
    logic        exc_valid = 1'b0;
    logic [5:0]  exc_num = '0;
    logic        exc_done, exc_fault;

    always #4 clk = ~clk;  // 125 MHz

    logic [31:0] tbl [0:63];
    assign mem_rdata = mem_valid ? tbl[mem_addr[7:2]] : 32'h0;

    boot_vector_seq dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .stack_ptr(stack_ptr),
        .prog_ctr(prog_ctr), .core_start(core_start), .thread_mode(thread_mode),
        .privileged(privileged), .boot_fault(boot_fault), .exc_valid(exc_valid),
        .exc_num(exc_num), .exc_done(exc_done), .exc_handler(exc_handler),
        .exc_fault(exc_fault)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Ready pattern: always ready or pseudo-random waits
    bit       rand_ready = 1'b1;
    bit [7:0] lfsr = 8'hB5;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = rand_ready ? (lfsr[0] & lfsr[2]) : 1'b1;
    end

    // Behavioural reference: phase numbers 0 idle,1 sp,2 pc,3 run,4 lookup,5 done
    int          ph = 0;
    logic [31:0] m_sp = 0, m_pc = 0, m_hnd = 0;
    logic        m_bf = 0, m_ef = 0;
    int          m_num = 0;
    bit          saw_start = 0;

    always @(negedge clk) begin
        logic        e_valid, e_start;
        logic [31:0] e_addr;
        e_valid = (ph == 1 || ph == 2 || ph == 4);
        e_start = (ph >= 3);
        e_addr  = (ph == 2) ? 32'h4 : (ph == 4) ? 32'(m_num * 4) : 32'h0;
        if (!rst_n) begin
            chk("R1 valid", {31'b0, mem_valid}, 0);
            chk("R1 start", {29'b0, core_start, thread_mode, privileged}, 0);
            chk("R1 done/fault", {30'b0, exc_done, boot_fault}, 0);
        end else begin
            chk("R6 valid", {31'b0, mem_valid}, {31'b0, e_valid});
            if (e_valid) begin
                if (ph == 1)      chk(exc_valid ? "R9 sp addr" : "R2 sp addr", mem_addr, e_addr);
                else if (ph == 2) chk(exc_valid ? "R9 pc addr" : "R3 pc addr", mem_addr, e_addr);
                else              chk("R7 lookup addr", mem_addr, e_addr);
            end
            chk("R5 start", {29'b0, core_start, thread_mode, privileged},
                {29'b0, e_start, e_start, e_start});
            chk("R8 done", {31'b0, exc_done}, {31'b0, (ph == 5)});
            if (e_start) begin
                chk("R2 stack", stack_ptr, m_sp);
                chk("R3 entry", prog_ctr, m_pc);
                chk("R4 fault", {31'b0, boot_fault}, {31'b0, m_bf});
            end
            if (ph == 5) begin
                chk("R8 handler", exc_handler, m_hnd);
                chk("R8 fault", {31'b0, exc_fault}, {31'b0, m_ef});
            end
        end
        // advance the model with the inputs sampled at the coming edge
        if (!rst_n) begin
            ph = 0; m_bf = 0; saw_start = 0;
        end else begin
            case (ph)
                0: ph = 1;
                1: if (mem_ready) begin m_sp = tbl[0] & ~32'h3; ph = 2; end
                2: if (mem_ready) begin m_pc = tbl[1] & ~32'h1; m_bf = ~tbl[1][0]; ph = 3; end
                3: if (exc_valid) begin m_num = int'(exc_num); ph = 4; end
                4: if (mem_ready) begin m_hnd = tbl[m_num] & ~32'h1; m_ef = ~tbl[m_num][0]; ph = 5; end
                default: ph = 3;
            endcase
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    task automatic do_exc(input int n);
        exc_valid = 1'b1;
        exc_num   = 6'(n);
        forever begin
            @(negedge clk);
            if (exc_done) break;
        end
        @(posedge clk); #1;
        exc_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) tbl[i] = {8'h00, 8'(i), 16'h0A01};
        tbl[0] = 32'h2000_0FFF;
        tbl[1] = 32'h0000_0201;
        tbl[5] = 32'h0000_0500;
        rand_ready = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        do_exc(2);      // R9: raised with reset release; NMI at 0x08 (R7)
        do_exc(3);      // R7: HardFault at 0x0C
        do_exc(16);     // R7: IRQ0 at 0x40
        do_exc(47);     // R7: IRQ31 at 0xBC
        do_exc(5);      // R8: handler word with bit 0 clear
        repeat (3) @(posedge clk);
        // second boot: entry word even (R4), no wait states
        #1 rst_n = 1'b0;
        tbl[1] = 32'h0000_0300;
        rand_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (8) @(posedge clk);
        #1;
        do_exc(16);
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule